// File: doc/BRIEF.md
# Camera Pixel Word Packer

This block collects samples from a parallel camera data bus and assembles them into 32-bit words, which a downstream FIFO or bus master then takes. A sample is taken on a clock edge only when the data-valid qualifier is high. A two-bit width select sets how many data lines are used.

In the narrowest mode, four 8-bit samples fill one word. In the three wider modes, each sample is zero-extended to a 16-bit halfword and two samples fill one word. The earliest sample always goes into the lowest-order position.

A frame-start pulse does three things: it captures the width select, restarts packing at the first slot, and throws away any word that was only partly filled. Each finished word is presented on a registered output together with a one-clock strobe.

Top module: `pix_word_packer`

## Requirements
- R1: The width select encodes 00 = 8 bits, 01 = 10 bits, 10 = 12 bits, 11 = 14 bits. A sample uses data lines [7:0], [9:0], [11:0] or [13:0] respectively. Lines above the selected width have no effect on the output.
- R2: In 8-bit mode, four accepted samples n..n+3 form one word. Sample n goes to bits 7:0, n+1 to 15:8, n+2 to 23:16 and n+3 to 31:24.
- R3: In the 10-, 12- and 14-bit modes, two accepted samples form one word. The first goes to bits 15:0 and the second to bits 31:16.
- R4: In the wider modes, halfword bits above the sample width read as zero. For 10 bits these are 15:10 and 31:26, for 12 bits 15:12 and 31:28, and for 14 bits 15:14 and 31:30.
- R5: Suppose the sample completing a word is accepted at a clock edge. At the following edge, the word output shows that word and the strobe is high for exactly that one clock. Words may complete on consecutive accepted samples without losing any.
- R6: A clock with the valid qualifier low accepts no sample and does not advance the packing position.
- R7: A frame-start pulse returns packing to slot 0 and discards a partially filled word, and no strobe follows. A sample presented in the same clock as frame start is not accepted.
- R8: The width select is captured only in a frame-start clock. Changes at any other time have no effect until the next frame start.
- R9: After reset, the strobe is low, the word output is zero and the captured mode is 8-bit.
- R10: Between strobes, the word output holds the last completed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Frame-start pulse; captures mode and clears packing |
| sample_vld_i | input | 1 | Data-valid qualifier for the current sample |
| width_sel_i | input | 2 | Sample width select (00/01/10/11 = 8/10/12/14 bits) |
| pix_data_i | input | 14 | Parallel camera data |
| word_o | output | 32 | Last completed packed word |
| word_vld_o | output | 1 | One-clock strobe when word_o is updated |

## Verification
A slot counter that drifts shows up as two symptoms: a strobe arriving one accepted sample early or late, and samples landing in the wrong lanes. Both appear at the first word boundary after the fault, which is at most four accepted samples away. A wrong captured mode shows up in the next completed word, as the wrong number of samples per word or as padding bits that are not zero. A reference model compares the strobe and the word on every clock, so a discrepancy is caught on the edge where it first appears.

// File: rtl/pkw_pkg.sv
package pkw_pkg;

  typedef enum logic [1:0] {
    PKW_W8  = 2'b00,
    PKW_W10 = 2'b01,
    PKW_W12 = 2'b10,
    PKW_W14 = 2'b11
  } pkw_width_e;

  // Number of meaningful data lines for a width code
  function automatic int unsigned pkw_bits(pkw_width_e m);
    return 32'd8 + 32'd2 * 32'(m);
  endfunction

endpackage

// File: rtl/pkw_lane_fmt.sv
module pkw_lane_fmt
  import pkw_pkg::*;
#(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned LANE_W = 16
) (
  input  logic [DATA_W-1:0] pix_i,
  input  pkw_width_e        mode_i,
  output logic [LANE_W-1:0] half_o
);

  int unsigned bits;

  always_comb begin
    bits = pkw_bits(mode_i);
  end

  // Keep each data line only when it lies inside the selected width
  for (genvar b = 0; b < LANE_W; b++) begin : g_bit
    localparam int unsigned BI = b;
    if (b < DATA_W) begin : g_live
      assign half_o[b] = pix_i[b] & (BI < bits);
    end else begin : g_pad
      assign half_o[b] = 1'b0;
    end
  end

endmodule

// File: rtl/pkw_slot_ctr.sv
module pkw_slot_ctr
  import pkw_pkg::*;
#(
  parameter int unsigned BYTE_SLOTS = 4,
  parameter int unsigned HALF_SLOTS = 2,
  localparam int unsigned SLOT_W    = $clog2(BYTE_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              adv_i,
  input  pkw_width_e        mode_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              last_o
);

  localparam logic [SLOT_W-1:0] BYTE_LAST = SLOT_W'(BYTE_SLOTS - 1);
  localparam logic [SLOT_W-1:0] HALF_LAST = SLOT_W'(HALF_SLOTS - 1);

  logic [SLOT_W-1:0] slot_q, slot_d;

  always_comb begin
    last_o = (mode_i == PKW_W8) ? (slot_q == BYTE_LAST) : (slot_q == HALF_LAST);
  end

  always_comb begin
    slot_d = slot_q;
    if (clr_i) begin
      slot_d = '0;
    end else if (adv_i) begin
      slot_d = last_o ? '0 : slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (clr_i || adv_i) begin
      slot_q <= slot_d;
    end
  end

  assign slot_o = slot_q;

endmodule

// File: rtl/pkw_accum.sv
module pkw_accum
  import pkw_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned LANE_W  = 16,
  parameter int unsigned SLOT_W  = 2,
  localparam int unsigned NBYTES = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic              last_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  pkw_width_e        mode_i,
  input  logic [LANE_W-1:0] half_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);

  logic [WORD_W-1:0] acc_q, acc_d, merged;
  logic [WORD_W-1:0] out_q, out_d;
  logic              vld_q, vld_d;
  logic              emit;

  // Per byte lane: which slot owns it and which half of the sample it takes
  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    localparam logic [SLOT_W-1:0] KB = SLOT_W'(k);
    localparam logic [SLOT_W-1:0] KH = SLOT_W'(k / 2);
    logic       hit;
    logic [7:0] dat;
    always_comb begin
      if (mode_i == PKW_W8) begin
        hit = wr_i && (slot_i == KB);
        dat = half_i[7:0];
      end else begin
        hit = wr_i && (slot_i == KH);
        dat = (k % 2 == 1) ? half_i[15:8] : half_i[7:0];
      end
      merged[k*8 +: 8] = hit ? dat : acc_q[k*8 +: 8];
    end
  end

  always_comb begin
    emit  = wr_i && last_i && !clr_i;
    acc_d = acc_q;
    if (clr_i || emit) begin
      acc_d = '0;
    end else if (wr_i) begin
      acc_d = merged;
    end
    out_d = emit ? merged : out_q;
    vld_d = emit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clr_i || wr_i) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (emit) begin
        out_q <= out_d;
      end
      vld_q <= vld_d;
    end
  end

  assign word_o     = out_q;
  assign word_vld_o = vld_q;

endmodule

// File: rtl/pix_word_packer.sv
module pix_word_packer
  import pkw_pkg::*;
#(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic              sample_vld_i,
  input  logic [1:0]        width_sel_i,
  input  logic [DATA_W-1:0] pix_data_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);

  localparam int unsigned LANE_W     = WORD_W / 2;
  localparam int unsigned BYTE_SLOTS = WORD_W / 8;
  localparam int unsigned HALF_SLOTS = WORD_W / LANE_W;
  localparam int unsigned SLOT_W     = $clog2(BYTE_SLOTS);

  pkw_width_e        mode_q, mode_d;
  logic [SLOT_W-1:0] slot_q;
  logic              last_slot;
  logic              accept;
  logic [LANE_W-1:0] half;

  // Mode is frozen for the whole frame
  always_comb begin
    mode_d = frame_start_i ? pkw_width_e'(width_sel_i) : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PKW_W8;
    end else if (frame_start_i) begin
      mode_q <= mode_d;
    end
  end

  assign accept = sample_vld_i && !frame_start_i;

  pkw_lane_fmt #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
  ) fmt_i (
    .pix_i  (pix_data_i),
    .mode_i (mode_q),
    .half_o (half)
  );

  pkw_slot_ctr #(
    .BYTE_SLOTS (BYTE_SLOTS),
    .HALF_SLOTS (HALF_SLOTS)
  ) ctr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (frame_start_i),
    .adv_i  (accept),
    .mode_i (mode_q),
    .slot_o (slot_q),
    .last_o (last_slot)
  );

  pkw_accum #(
    .WORD_W (WORD_W),
    .LANE_W (LANE_W),
    .SLOT_W (SLOT_W)
  ) acc_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (frame_start_i),
    .wr_i       (accept),
    .last_i     (last_slot),
    .slot_i     (slot_q),
    .mode_i     (mode_q),
    .half_i     (half),
    .word_o     (word_o),
    .word_vld_o (word_vld_o)
  );

endmodule

// File: rtl/pkw_checker.sv
module pkw_checker #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned SLOT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start_i,
  input logic              sample_vld_i,
  input logic [1:0]        mode_q,
  input logic [SLOT_W-1:0] slot_q,
  input logic [WORD_W-1:0] word_o,
  input logic              word_vld_o
);

  localparam int unsigned HALF = WORD_W / 2;

  int unsigned pad_from;
  always_comb begin
    pad_from = 32'd8 + 32'd2 * 32'(mode_q);
  end

  // R5: the strobe never lasts more than one clock
  p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |=> !word_vld_o);

  // R6, R7: a strobe needs an accepted sample on the previous edge
  p_strobe_needs_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_vld_o) |-> $past(sample_vld_i && !frame_start_i));

  // R10: output word holds between strobes
  p_hold_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld_o |=> (word_vld_o || $stable(word_o)));

  // R4: padding bits of both halfwords are zero in wide modes
  p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_o && mode_q != 2'b00) |->
      (((word_o[HALF-1:0] >> pad_from) == '0) &&
       ((word_o[WORD_W-1:HALF] >> pad_from) == '0)));

  // R3: only two slots are used in wide modes
  p_wide_slots_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'b00) |-> (slot_q < SLOT_W'(2)));

  // R7: frame start returns packing to slot 0
  p_frame_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> (slot_q == '0));

  // R8: the captured mode changes only after a frame-start clock
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start_i |=> $stable(mode_q));

endmodule

bind pix_word_packer pkw_checker #(
  .WORD_W (WORD_W),
  .SLOT_W (SLOT_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_start_i (frame_start_i),
  .sample_vld_i  (sample_vld_i),
  .mode_q        (mode_q),
  .slot_q        (slot_q),
  .word_o        (word_o),
  .word_vld_o    (word_vld_o)
);

// File: tb/pix_word_packer_tb_top.sv
module pix_word_packer_tb_top;

  logic        clk;
  logic        rst_n;
  logic        frame_start_i;
  logic        sample_vld_i;
  logic [1:0]  width_sel_i;
  logic [13:0] pix_data_i;
  logic [31:0] word_o;
  logic        word_vld_o;

  int checks;
  int fails;
  bit done;

  // reference model state
  int          m_mode;
  logic [31:0] m_q[$];
  logic [31:0] exp_word;
  logic        exp_vld;
  int unsigned seed;

  pix_word_packer dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (frame_start_i),
    .sample_vld_i  (sample_vld_i),
    .width_sel_i   (width_sel_i),
    .pix_data_i    (pix_data_i),
    .word_o        (word_o),
    .word_vld_o    (word_vld_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, compare after it
  task automatic step(input bit fs, input bit vld, input logic [1:0] ws,
                      input logic [13:0] d, input string tag);
    int bits;
    int spw;
    int sh;
    logic [31:0] w;
    @(negedge clk);
    frame_start_i = fs;
    sample_vld_i  = vld;
    width_sel_i   = ws;
    pix_data_i    = d;
    @(posedge clk);
    #1;
    exp_vld = 1'b0;
    if (fs) begin
      m_q.delete();
      m_mode = int'(ws);
    end else if (vld) begin
      bits = 8 + 2 * m_mode;
      m_q.push_back(32'(d) & ((32'd1 << bits) - 32'd1));
      spw = (m_mode == 0) ? 4 : 2;
      sh  = (m_mode == 0) ? 8 : 16;
      if (m_q.size() == spw) begin
        w = '0;
        foreach (m_q[i]) w = w | (m_q[i] << (sh * i));
        exp_word = w;
        exp_vld  = 1'b1;
        m_q.delete();
      end
    end
    check(tag, {31'd0, word_vld_o}, {31'd0, exp_vld}, "strobe");
    check(tag, word_o, exp_word, "word");
  endtask

  function automatic logic [13:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[29:16];
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 0; seed = 32'h1234;
    m_mode = 0; exp_word = '0; exp_vld = 1'b0;
    rst_n = 1'b0; frame_start_i = 0; sample_vld_i = 0; width_sel_i = 0; pix_data_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", {31'd0, word_vld_o}, 32'd0, "reset strobe");
    check("R9", word_o, 32'd0, "reset word");
    rst_n = 1'b1;

    // R9 / R1: default 8-bit mode before any frame start, upper lines ignored
    step(0, 1, 2'b11, 14'h3F12, "R9");
    step(0, 1, 2'b11, 14'h2A34, "R1");
    step(0, 1, 2'b10, 14'h1556, "R1");
    step(0, 1, 2'b01, 14'h3F78, "R9");
    step(0, 0, 2'b00, 14'h0000, "R10");

    // R2 / R6: 8-bit order with invalid gaps
    step(1, 0, 2'b00, 14'h0, "R7");
    for (int i = 0; i < 12; i++) begin
      step(0, 1, 2'b00, 14'(8'h11 * (i + 1)), "R2");
      if (i % 3 == 1) step(0, 0, 2'b00, 14'h3FFF, "R6");
    end

    // R3 / R4: each wide mode with all lines high and random data
    for (int m = 1; m < 4; m++) begin
      step(1, 0, 2'(m), 14'h0, "R8");
      step(0, 1, 2'(m), 14'h3FFF, "R4");
      step(0, 1, 2'(m), 14'h3FFF, "R4");
      for (int i = 0; i < 8; i++) step(0, 1, 2'(m), rnd(), "R3");
      step(0, 0, 2'(m), rnd(), "R10");
      step(0, 0, 2'(m), rnd(), "R10");
      // R5: back-to-back words
      for (int i = 0; i < 6; i++) step(0, 1, 2'(m), rnd(), "R5");
    end

    // R7: partial word discarded, sample in frame-start clock dropped
    step(1, 0, 2'b00, 14'h0, "R7");
    step(0, 1, 2'b00, 14'h00AA, "R7");
    step(0, 1, 2'b00, 14'h00BB, "R7");
    step(1, 1, 2'b01, 14'h03CC, "R7");
    step(0, 1, 2'b01, 14'h0311, "R7");
    step(0, 1, 2'b01, 14'h0222, "R7");
    step(0, 1, 2'b01, 14'h0133, "R7");
    step(1, 1, 2'b00, 14'h0044, "R7");
    for (int i = 0; i < 4; i++) step(0, 1, 2'b00, rnd(), "R7");

    // R8: width select changes mid-frame are ignored
    step(1, 0, 2'b10, 14'h0, "R8");
    step(0, 1, 2'b00, 14'h3FFF, "R8");
    step(0, 1, 2'b11, 14'h3FFF, "R8");
    step(0, 1, 2'b01, 14'h2ABC, "R8");
    step(0, 1, 2'b00, 14'h1DEF, "R8");
    for (int i = 0; i < 20; i++) step(0, (i % 3) != 0, 2'(i), rnd(), "R6");

    done = 1;
    summary();
    $finish;
  end

endmodule